// File: doc/BRIEF.md
# FSK Modem Configuration Register Bank

This block keeps the run-time setup of an FSK power-line modem in three 8-bit registers. A host processor loads and inspects them over a four-wire synchronous serial port made of an active-low chip select, a serial clock, a data input and a data output. The serial pins are sampled by the block's own system clock, which must run well above the serial clock. Every serial transfer is 16 bits long. It carries a read/write flag, a 7-bit register address and one data byte.

The register contents drive parallel control outputs to the modem:
- a 9-bit mark-frequency code that is split across two registers, giving a mark frequency of (426 + code) x 150 Hz;
- the baud/deviation select and the receive-bandwidth select;
- the zero-crossing sync disable, the transmit-timeout disable and power-down;
- eight test and debug controls.

Reset loads fixed, non-zero defaults into the registers. A write takes effect only when the transfer is complete and the chip select is released.

The serial engine is a state machine with these states:
- `ST_IDLE`: chip select is inactive.
- `ST_HDR`: the flag and the address are being shifted in.
- `ST_WDATA` or `ST_RDATA`: the data phase of a write or a read.
- `ST_FULL`: exactly 16 bits have been received.
- `ST_SPILL`: more than 16 bits have been received.

The transitions are:
- start: `ST_IDLE` to `ST_HDR` when chip select becomes active.
- header done: `ST_HDR` to `ST_RDATA` or `ST_WDATA` on the 8th rising clock edge, chosen by the flag.
- frame done: the data state to `ST_FULL` on the 16th rising edge.
- overrun: `ST_FULL` to `ST_SPILL` on any further rising edge.
- abort: any state to `ST_IDLE` when chip select is released. A write is committed only on the release from `ST_FULL`.

Top module: `fsk_cfg_regbank`

## Requirements
- R1: After reset the registers hold these values:

  | Address | Value |
  |---|---|
  | 00h | C5h |
  | 01h | 2Fh |
  | 02h | 00h |

  The outputs are therefore mark_code = 453, baud_sel = 2'b11, rx_bw = 2'b01, zc_sync_off = 1, tx_timeout_off = 0, power_down = 0, and all test outputs 0.
- R2: A transfer is framed by cs_n low. The block samples sdi on rising sclk edges, MSB first:
  - frame bit 15 is the flag (0 = write, 1 = read);
  - bits 14:8 are the address;
  - bits 7:0 are the data.
- R3: A write updates the register only when cs_n rises after exactly 16 rising sclk edges. A transfer with fewer or more edges leaves every register unchanged.
- R4: On a read, the falling sclk edge after the 8th rising edge puts data bit 7 on sdo. Each later falling edge presents the next lower bit.
- R5: sdo is 0 while cs_n is high.
- R6: The field positions are as follows:

  | Register | Bits | Output |
  |---|---|---|
  | 00h | 7:0 | mark_code[7:0] |
  | 01h | 0 | mark_code[8] |
  | 01h | 2:1 | baud_sel |
  | 01h | 4:3 | rx_bw |
  | 01h | 5 | zc_sync_off |
  | 01h | 6 | tx_timeout_off |
  | 01h | 7 | power_down |
  | 02h | 1:0 | test_mode |
  | 02h | 2 | rx_async |
  | 02h | 3 | agc_hold |
  | 02h | 4 | dig_mixer |
  | 02h | 5 | test_in_off |
  | 02h | 6 | tx_edge_sample |
  | 02h | 7 | fast_cd |

- R7: A write to any address above 02h changes nothing. A read from such an address returns 00h.
- R8: A write to 00h changes only mark_code[7:0]. A write to 01h sets mark_code[8] from its bit 0 and leaves the low eight bits alone.
- R9: sclk edges and sdi activity while cs_n is high change no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock |
| sdi | input | 1 | Serial data into the block |
| sdo | output | 1 | Serial read data, 0 when idle |
| mark_code | output | 9 | Mark-frequency code |
| baud_sel | output | 2 | Baud rate and deviation select |
| rx_bw | output | 2 | Receive band-pass bandwidth select |
| zc_sync_off | output | 1 | Disables zero-crossing transmit sync |
| tx_timeout_off | output | 1 | Disables the transmit timeout |
| power_down | output | 1 | Power-down request |
| test_mode | output | 2 | Test mode select |
| rx_async | output | 1 | Unsynchronised receive data |
| agc_hold | output | 1 | Freeze the AGC counter |
| dig_mixer | output | 1 | Select the digital mixer |
| test_in_off | output | 1 | Test pin restricted to output |
| tx_edge_sample | output | 1 | Sample transmit data on clock edge |
| fast_cd | output | 1 | Faster carrier-detect timing |

## Verification
A vector table of writes, each followed by a readback, checks the main path:
- all-ones and all-zeros bytes expose stuck or swapped field bits;
- writes to 00h and to 01h alone separate the two halves of the 9-bit mark code;
- writes to 02h and to the unmapped addresses 05h and 7Fh show whether the decode accepts or drops them.

Directed transfers of 15 and 17 clocks tell a correctly counted frame from a miscounted one. Clock toggling with chip select high shows whether the serial pins are gated. A mid-run reset shows that the defaults are reloaded.

// File: rtl/fsk_cfg_pkg.sv
package fsk_cfg_pkg;
    localparam int ADDR_W     = 7;
    localparam int DATA_W     = 8;
    localparam int NUM_REGS   = 3;
    localparam int HDR_BITS   = 1 + ADDR_W;
    localparam int FRAME_BITS = HDR_BITS + DATA_W;
    localparam int CNT_W      = $clog2(FRAME_BITS + 2);
    localparam logic [8:0] MARK_RESET = 9'd453;

    typedef enum logic [2:0] {
        ST_IDLE, ST_HDR, ST_WDATA, ST_RDATA, ST_FULL, ST_SPILL
    } ser_state_t;

    // Reset value per register index; register 01h packs mark bit 8 at bit 0.
    function automatic logic [DATA_W-1:0] reg_default(input int idx);
        case (idx)
            0:       return MARK_RESET[7:0];
            1:       return {1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, MARK_RESET[8]};
            default: return '0;
        endcase
    endfunction
endpackage

// File: rtl/fsk_cfg_sync.sv
module fsk_cfg_sync #(
    parameter int W = 3,
    parameter logic [W-1:0] RESET_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= RESET_VAL;
            q    <= RESET_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/fsk_cfg_serial_fsm.sv
module fsk_cfg_serial_fsm
    import fsk_cfg_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n_s,
    input  logic          sclk_s,
    input  logic          sdi_s,
    input  logic [DW-1:0] rd_data,
    output logic [AW-1:0] rd_addr,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          sdo
);
    localparam int HB = 1 + AW;
    localparam int FB = HB + DW;
    localparam int CW = $clog2(FB + 2);
    localparam logic [CW-1:0] HDR_LAST = CW'(HB - 1);
    localparam logic [CW-1:0] FRM_LAST = CW'(FB - 1);
    localparam logic [CW-1:0] FRM_FULL = CW'(FB);
    localparam logic [CW-1:0] RD_FIRST = CW'(HB);

    ser_state_t    state, state_nx;
    logic          sclk_q;
    logic          cs_act, rise, fall, counting;
    logic [FB-1:0] shreg;
    logic [CW-1:0] bit_cnt;
    logic          rd_flag;
    logic [DW-1:0] rd_shift;
    logic          sdo_q;

    assign cs_act   = !cs_n_s;
    assign rise     = cs_act && sclk_s && !sclk_q;
    assign fall     = cs_act && !sclk_s && sclk_q;
    assign counting = (state == ST_HDR) || (state == ST_WDATA) ||
                      (state == ST_RDATA) || (state == ST_FULL);
    assign rd_addr  = shreg[AW-1:0];
    assign sdo      = sdo_q;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (cs_act) state_nx = ST_HDR;
            ST_HDR: begin
                if (!cs_act) state_nx = ST_IDLE;
                else if (rise && bit_cnt == HDR_LAST)
                    state_nx = shreg[HB-2] ? ST_RDATA : ST_WDATA;
            end
            ST_WDATA, ST_RDATA: begin
                if (!cs_act) state_nx = ST_IDLE;
                else if (rise && bit_cnt == FRM_LAST) state_nx = ST_FULL;
            end
            ST_FULL: begin
                if (!cs_act) state_nx = ST_IDLE;
                else if (rise) state_nx = ST_SPILL;
            end
            ST_SPILL: if (!cs_act) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q   <= 1'b0;
            shreg    <= '0;
            bit_cnt  <= '0;
            rd_flag  <= 1'b0;
            rd_shift <= '0;
            sdo_q    <= 1'b0;
            wr_en    <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else begin
            sclk_q <= sclk_s;
            wr_en  <= 1'b0;
            if (state_nx == ST_IDLE) begin
                bit_cnt <= '0;
                sdo_q   <= 1'b0;
            end else if (rise && counting) begin
                shreg   <= {shreg[FB-2:0], sdi_s};
                bit_cnt <= bit_cnt + 1'b1;
            end
            if (state == ST_HDR && state_nx == ST_RDATA) rd_flag <= 1'b1;
            if (state == ST_HDR && state_nx == ST_WDATA) rd_flag <= 1'b0;
            if (state == ST_RDATA && fall) begin
                if (bit_cnt == RD_FIRST) {sdo_q, rd_shift} <= {rd_data, 1'b0};
                else                     {sdo_q, rd_shift} <= {rd_shift, 1'b0};
            end
            if (state == ST_FULL && !cs_act && !rd_flag) begin
                wr_en   <= 1'b1;
                wr_addr <= shreg[FB-2 -: AW];
                wr_data <= shreg[DW-1:0];
            end
        end
    end

    // R3: a commit pulse only follows a frame of exactly FB bits
    a_r3_commit_full: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (bit_cnt == '0 && $past(bit_cnt) == FRM_FULL));
    // R2: the bit counter never runs past one overrun edge
    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CW'(FB + 1));
    // R5: serial output quiet while idle
    a_r5_sdo_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && $past(state) == ST_IDLE) |-> !sdo_q);
endmodule

// File: rtl/fsk_cfg_regfile.sv
module fsk_cfg_regfile
    import fsk_cfg_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int NR = NUM_REGS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [DW-1:0]    wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [DW-1:0]    rd_data,
    output logic [NR*DW-1:0] regs_flat
);
    logic [DW-1:0] regs [NR];

    for (genvar i = 0; i < NR; i++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                  regs[i] <= reg_default(i);
            else if (wr_en && wr_addr == AW'(i))         regs[i] <= wr_data;
        end
        assign regs_flat[i*DW +: DW] = regs[i];
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NR; i++)
            if (rd_addr == AW'(i)) rd_data = regs[i];
    end

    // R3: no commit, no change
    a_r3_hold_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs_flat));
    // R7: unmapped addresses never alter storage
    a_r7_high_addr_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr >= AW'(NR)) |=> $stable(regs_flat));
endmodule

// File: rtl/fsk_cfg_regbank.sv
module fsk_cfg_regbank
    import fsk_cfg_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int NR = NUM_REGS
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       sclk,
    input  logic       sdi,
    output logic       sdo,
    output logic [8:0] mark_code,
    output logic [1:0] baud_sel,
    output logic [1:0] rx_bw,
    output logic       zc_sync_off,
    output logic       tx_timeout_off,
    output logic       power_down,
    output logic [1:0] test_mode,
    output logic       rx_async,
    output logic       agc_hold,
    output logic       dig_mixer,
    output logic       test_in_off,
    output logic       tx_edge_sample,
    output logic       fast_cd
);
    logic [2:0]       pins_s;
    logic             wr_en;
    logic [AW-1:0]    wr_addr, rd_addr;
    logic [DW-1:0]    wr_data, rd_data;
    logic [NR*DW-1:0] regs_flat;
    logic [DW-1:0]    r_mark, r_glob, r_test;

    fsk_cfg_sync #(.W(3), .RESET_VAL(3'b100)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({cs_n, sclk, sdi}), .q(pins_s));

    fsk_cfg_serial_fsm #(.AW(AW), .DW(DW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .cs_n_s(pins_s[2]), .sclk_s(pins_s[1]),
        .sdi_s(pins_s[0]), .rd_data(rd_data), .rd_addr(rd_addr),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .sdo(sdo));

    fsk_cfg_regfile #(.AW(AW), .DW(DW), .NR(NR)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .regs_flat(regs_flat));

    assign r_mark = regs_flat[0*DW +: DW];
    assign r_glob = regs_flat[1*DW +: DW];
    assign r_test = regs_flat[2*DW +: DW];

    assign mark_code      = {r_glob[0], r_mark};
    assign baud_sel       = r_glob[2:1];
    assign rx_bw          = r_glob[4:3];
    assign zc_sync_off    = r_glob[5];
    assign tx_timeout_off = r_glob[6];
    assign power_down     = r_glob[7];
    assign test_mode      = r_test[1:0];
    assign rx_async       = r_test[2];
    assign agc_hold       = r_test[3];
    assign dig_mixer      = r_test[4];
    assign test_in_off    = r_test[5];
    assign tx_edge_sample = r_test[6];
    assign fast_cd        = r_test[7];

    // R1: defaults visible on the first edge out of reset
    a_r1_reset_mark: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (mark_code == MARK_RESET && baud_sel == 2'b11 && !power_down));
    // R8: mark bit 8 only moves with a write cycle
    a_r8_mark_msb_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(mark_code));
endmodule

// File: tb/tb_fsk_cfg_regbank.sv
module tb_fsk_cfg_regbank;
    localparam int HALF_SCK = 128;
    localparam int NVEC = 10;
    // {addr, write data, expected readback}
    localparam logic [22:0] VEC [NVEC] = '{
        {7'h00, 8'h3A, 8'h3A}, {7'h01, 8'h80, 8'h80}, {7'h02, 8'hA5, 8'hA5},
        {7'h01, 8'h01, 8'h01}, {7'h00, 8'hFF, 8'hFF}, {7'h00, 8'h00, 8'h00},
        {7'h05, 8'h77, 8'h00}, {7'h7F, 8'hFF, 8'h00}, {7'h02, 8'h00, 8'h00},
        {7'h01, 8'h7E, 8'h7E}
    };

    logic clk = 0, rst_n = 0, cs_n = 1, sclk = 0, sdi = 0;
    logic sdo, zc_sync_off, tx_timeout_off, power_down;
    logic rx_async, agc_hold, dig_mixer, test_in_off, tx_edge_sample, fast_cd;
    logic [8:0] mark_code;
    logic [1:0] baud_sel, rx_bw, test_mode;
    logic [7:0] shadow [3];
    int n_chk = 0, n_bad = 0;

    always #4 clk = ~clk;

    fsk_cfg_regbank dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic [15:0] frame, input int nbits, output logic [7:0] rd);
        rd = '0;
        cs_n = 0; #200;
        for (int i = 0; i < nbits; i++) begin
            sdi = (i < 16) ? frame[15-i] : 1'b0;
            #HALF_SCK;
            if (i >= 8 && i < 16) rd[15-i] = sdo;
            sclk = 1; #HALF_SCK; sclk = 0;
        end
        #HALF_SCK; cs_n = 1; #400;
    endtask

    task automatic chk_ports(input string req);
        chk(req, {power_down, tx_timeout_off, zc_sync_off, rx_bw, baud_sel, mark_code,
                  fast_cd, tx_edge_sample, test_in_off, dig_mixer, agc_hold, rx_async, test_mode},
                 {shadow[1][7:1], shadow[1][0], shadow[0], shadow[2]});
    endtask

    task automatic chk_defaults(input string req);
        logic [7:0] rd;
        shadow[0] = 8'hC5; shadow[1] = 8'h2F; shadow[2] = 8'h00;
        chk({req, " mark"}, mark_code, 9'd453);
        chk({req, " glob"}, {power_down, tx_timeout_off, zc_sync_off, rx_bw, baud_sel}, 7'b0010111);
        chk_ports(req);
        for (int a = 0; a < 3; a++) begin
            xfer({1'b1, 7'(a), 8'h00}, 16, rd);
            chk({req, " readback"}, rd, shadow[a]);
        end
    endtask

    initial begin
        #(200000 * 8);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        #50; rst_n = 1; #100;
        chk("R5 idle sdo", sdo, 0);
        chk_defaults("R1");

        // Table walk: R2 R4 R6 R7 R8
        for (int v = 0; v < NVEC; v++) begin
            xfer({1'b0, VEC[v][22:16], VEC[v][15:8]}, 16, rd);
            if (VEC[v][22:16] < 3) shadow[VEC[v][22:16]] = VEC[v][15:8];
            xfer({1'b1, VEC[v][22:16], 8'h00}, 16, rd);
            chk("R4 R7 readback", rd, VEC[v][7:0]);
            chk_ports("R6 R8 fields");
            chk("R5 sdo after cs release", sdo, 0);
        end

        // R3: short and long frames are discarded
        xfer({1'b0, 7'h00, 8'h5A}, 15, rd);
        chk_ports("R3 short frame");
        xfer({1'b0, 7'h02, 8'hFF}, 17, rd);
        chk_ports("R3 long frame");
        xfer({1'b1, 7'h02, 8'h00}, 16, rd);
        chk("R3 long frame readback", rd, shadow[2]);

        // R9: clocking with chip select high
        for (int i = 0; i < 20; i++) begin
            sdi = i[0]; #HALF_SCK; sclk = 1; #HALF_SCK; sclk = 0;
            if (sdo !== 1'b0) chk("R9 R5 sdo while deselected", sdo, 0);
        end
        #400;
        chk_ports("R9 deselected clocks");
        chk("R9 R5 sdo", sdo, 0);

        // R1: reset restores defaults after writes
        xfer({1'b0, 7'h02, 8'hC3}, 16, rd);
        rst_n = 0; #40; rst_n = 1; #100;
        chk_defaults("R1 re-reset");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule